// File: doc/BRIEF.md
# Save/Restore DMA Transfer Counters

This block holds two independent 16-bit transfer counters, one for the playback stream and one for the recording stream. Software reaches them through an 8-bit indexed register port, where each counter shows up as a low-byte index and a high-byte index. A driver programs a counter with the number of bytes to move minus one. The counter then counts down once for every completed byte transfer. When a decrement would go below zero, the counter raises a one-cycle terminal-count pulse and reloads the value it was last given.

Reading the indices returns the live count, not the programmed value. A driver that is about to suspend can therefore save how far a transfer has gone. On resume it writes the saved bytes back. A low-byte write only stages its data. The full 16-bit value takes effect in a single cycle when the matching high byte is written, so the counter never runs with half of a new value.

A low-byte read also freezes the high byte of that same instant into a per-channel shadow. The next high-byte read of that channel returns the shadow, which makes a low-then-high 16-bit read coherent even while transfers continue.

Top module: `dma_xfer_counter`

## Requirements
- R1: After reset, reads of indices 0Bh and 0Ch (playback low and high) and of 0Dh and 0Eh (recording low and high) each return FFh. After reset, reg_rdata is 00h and both terminal-count outputs are low.
- R2: A write to a low-byte index (0Bh or 0Dh) only stages the byte. Readback of that counter is unchanged until the matching high byte is written.
- R3: A write to a high-byte index (0Ch or 0Eh) loads the counter with {written byte, staged low byte} in one step. The same value becomes the reload value.
- R4: Each pulse on xfer_stb[c] (bit 0 playback, bit 1 recording) decrements that counter by one. A read puts its byte on reg_rdata one cycle after reg_rd is sampled.
- R5: A strobe while the counter is 0000h reloads the last loaded value and drives tc_pulse[c] high for exactly the following cycle. A programmed value of N-1 therefore gives the pulse on the Nth strobe.
- R6: A high-byte write in the same cycle as a strobe on that channel loads the new value. The decrement of that cycle is dropped and no terminal-count pulse is produced.
- R7: A low-byte read saves the high byte of the same instant. The next high-byte read of that channel returns the saved byte even if the counter changed in between.
- R8: A high-byte read with no pending saved byte returns the live high byte. A high-byte read consumes the saved byte, and a high-byte write discards it.
- R9: The two counters are independent. A strobe or write on one channel never changes the other channel's count or terminal-count output.
- R10: A read of any index outside 0Bh..0Eh returns 00h. A write to such an index changes no counter.
- R11: reg_rdata holds its value in every cycle where no read is sampled, including cycles in which the counters move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 8 | Register index |
| reg_wr | input | 1 | Write strobe for reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rd | input | 1 | Read strobe for reg_addr |
| reg_rdata | output | 8 | Registered read data |
| xfer_stb | input | 2 | Per-channel byte-transfer strobe (bit 0 playback, bit 1 recording) |
| tc_pulse | output | 2 | Per-channel terminal-count pulse |

## Verification
The bench covers five corner cases:
- A low-byte write followed by a read. A design that loaded on the low write would return the staged byte early.
- Underflow on a counter loaded with 0002h. A design with an off-by-one would raise the terminal-count pulse one strobe early or late, or would fail to restore the reload value.
- A high-byte write landing in the same cycle as a strobe. A design that lets the decrement win, or that fires the pulse, would read back one less than written.
- Low-then-high reads with a transfer in between, plus a second high read and a high write that must discard the saved byte. A design that skips the shadow, or never clears it, returns a torn or stale high byte.
- Strobes on one channel while the other channel is read back, and accesses to unmapped indices. These expose any cross-coupling and any stray decode.

// File: rtl/dma_xfer_pkg.sv
// Package: shared types for the save/restore DMA transfer counters.
// Assumes one register access per cycle on the indexed port.
package dma_xfer_pkg;

    // Per-channel access strobes produced by the index decoder.
    typedef struct packed {
        logic wr_lo;   // write to the channel's low-byte index
        logic wr_hi;   // write to the channel's high-byte index
        logic rd_lo;   // read of the channel's low-byte index
        logic rd_hi;   // read of the channel's high-byte index
    } chan_acc_t;

    // Bytes per counter; the two-index layout per channel depends on it.
    localparam int unsigned BYTES_PER_CNT = 2;

endpackage

// File: rtl/dma_idx_decode.sv
// Module: dma_idx_decode
// Turns the indexed register port into per-channel access strobes.
// Channel c owns index BASE_IDX+2c (low byte) and BASE_IDX+2c+1 (high byte).
// Assumes reg_wr and reg_rd are not both asserted in one cycle.
module dma_idx_decode
    import dma_xfer_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned BASE_IDX = 11
) (
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    output chan_acc_t [NUM_CH-1:0]      acc_o,
    output logic                        rd_unmapped_o
);

    logic [NUM_CH-1:0] rd_hit;

    // One decoder slice per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] LO_IDX =
            ADDR_W'(BASE_IDX + BYTES_PER_CNT * c);
        localparam logic [ADDR_W-1:0] HI_IDX =
            ADDR_W'(BASE_IDX + BYTES_PER_CNT * c + 1);

        logic is_lo;
        logic is_hi;

        // Index match for this channel's two bytes.
        assign is_lo = (reg_addr == LO_IDX);
        assign is_hi = (reg_addr == HI_IDX);

        // Qualify matches with the access direction.
        assign acc_o[c].wr_lo = reg_wr && is_lo;
        assign acc_o[c].wr_hi = reg_wr && is_hi;
        assign acc_o[c].rd_lo = reg_rd && is_lo;
        assign acc_o[c].rd_hi = reg_rd && is_hi;
        assign rd_hit[c]      = reg_rd && (is_lo || is_hi);
    end

    // A read that no channel claims returns zero.
    assign rd_unmapped_o = reg_rd && (rd_hit == '0);

endmodule

// File: rtl/dma_chan_counter.sv
// Module: dma_chan_counter
// One down-counter with a staged low byte, an atomic 16-bit load on the
// high-byte write, and reload plus a one-cycle terminal pulse on underflow.
// Assumes wr_lo and wr_hi are never high together (single-index port).
module dma_chan_counter #(
    parameter int unsigned REG_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [REG_W-1:0]     wdata,
    input  logic                 xfer,
    output logic [2*REG_W-1:0]   count_o,
    output logic                 tc_o
);

    localparam int unsigned CNT_W = 2 * REG_W;
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [REG_W-1:0] stage_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] reload_q;
    logic             tc_q;
    logic [CNT_W-1:0] load_val;

    // Full value formed from the incoming high byte and the staged low byte.
    assign load_val = {wdata, stage_q};

    // Stage the low byte; it has no effect until the high byte arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else if (wr_lo) begin
            stage_q <= wdata;
        end
    end

    // Load wins over a strobe; a strobe at zero reloads and pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q    <= '1;
            reload_q <= '1;
            tc_q     <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            if (wr_hi) begin
                cnt_q    <= load_val;
                reload_q <= load_val;
            end else if (xfer) begin
                if (cnt_q == '0) begin
                    cnt_q <= reload_q;
                    tc_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_ONE;
                end
            end
        end
    end

    assign count_o = cnt_q;
    assign tc_o    = tc_q;

endmodule

// File: rtl/dma_read_port.sv
// Module: dma_read_port
// Registered readback of the live counters, with a per-channel shadow that
// freezes the high byte on a low-byte read for a coherent 16-bit read.
// Assumes at most one access strobe is active per cycle.
module dma_read_port
    import dma_xfer_pkg::*;
#(
    parameter int unsigned NUM_CH = 2,
    parameter int unsigned REG_W  = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  chan_acc_t [NUM_CH-1:0]             acc_i,
    input  logic                               rd_unmapped_i,
    input  logic [NUM_CH-1:0][2*REG_W-1:0]     counts_i,
    output logic [REG_W-1:0]                   rdata_o
);

    localparam int unsigned CNT_W = 2 * REG_W;

    logic [NUM_CH-1:0][REG_W-1:0] shadow_all;
    logic [NUM_CH-1:0]            shv_all;
    logic [REG_W-1:0]             rd_next;
    logic                         rd_any;
    logic [REG_W-1:0]             rdata_q;

    // One shadow byte and pending flag per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_sh
        logic [REG_W-1:0] sh_q;
        logic             shv_q;

        // Capture on low read; consume on high read; drop on high write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_q  <= '1;
                shv_q <= 1'b0;
            end else if (acc_i[c].rd_lo) begin
                sh_q  <= counts_i[c][CNT_W-1:REG_W];
                shv_q <= 1'b1;
            end else if (acc_i[c].rd_hi || acc_i[c].wr_hi) begin
                shv_q <= 1'b0;
            end
        end

        assign shadow_all[c] = sh_q;
        assign shv_all[c]    = shv_q;
    end

    // Select the byte the current read returns.
    always_comb begin
        rd_any  = rd_unmapped_i;
        rd_next = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (acc_i[c].rd_lo) begin
                rd_any  = 1'b1;
                rd_next = counts_i[c][REG_W-1:0];
            end
            if (acc_i[c].rd_hi) begin
                rd_any  = 1'b1;
                rd_next = shv_all[c] ? shadow_all[c]
                                     : counts_i[c][CNT_W-1:REG_W];
            end
        end
    end

    // Register the read byte; hold it when no read is sampled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_any) begin
            rdata_q <= rd_next;
        end
    end

    assign rdata_o = rdata_q;

endmodule

// File: rtl/dma_xfer_counter.sv
// Module: dma_xfer_counter (top)
// Playback and recording transfer counters behind an 8-bit indexed port.
// Channel 0 is playback (indices 0Bh/0Ch), channel 1 recording (0Dh/0Eh).
// Assumes the host issues at most one read or write per cycle.
module dma_xfer_counter
    import dma_xfer_pkg::*;
#(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned BASE_IDX = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic              reg_rd,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic [NUM_CH-1:0] xfer_stb,
    output logic [NUM_CH-1:0] tc_pulse
);

    localparam int unsigned CNT_W = BYTES_PER_CNT * REG_W;

    chan_acc_t [NUM_CH-1:0]          acc;
    logic                            rd_unmapped;
    logic [NUM_CH-1:0][CNT_W-1:0]    counts;

    // Index decode into per-channel strobes.
    dma_idx_decode #(
        .NUM_CH   (NUM_CH),
        .ADDR_W   (ADDR_W),
        .BASE_IDX (BASE_IDX)
    ) u_decode (
        .reg_addr      (reg_addr),
        .reg_wr        (reg_wr),
        .reg_rd        (reg_rd),
        .acc_o         (acc),
        .rd_unmapped_o (rd_unmapped)
    );

    // One independent counter per channel.
    for (genvar c = 0; c < NUM_CH; c++) begin : g_cnt
        dma_chan_counter #(
            .REG_W (REG_W)
        ) u_cnt (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_lo   (acc[c].wr_lo),
            .wr_hi   (acc[c].wr_hi),
            .wdata   (reg_wdata),
            .xfer    (xfer_stb[c]),
            .count_o (counts[c]),
            .tc_o    (tc_pulse[c])
        );
    end

    // Readback path with coherent-read shadow.
    dma_read_port #(
        .NUM_CH (NUM_CH),
        .REG_W  (REG_W)
    ) u_rdport (
        .clk           (clk),
        .rst_n         (rst_n),
        .acc_i         (acc),
        .rd_unmapped_i (rd_unmapped),
        .counts_i      (counts),
        .rdata_o       (reg_rdata)
    );

endmodule

// File: rtl/dma_xfer_counter_chk.sv
// Module: dma_xfer_counter_chk
// Port-level properties of the transfer counters, bound to the top.
module dma_xfer_counter_chk #(
    parameter int unsigned NUM_CH   = 2,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned BASE_IDX = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [REG_W-1:0]  reg_rdata,
    input logic [NUM_CH-1:0] xfer_stb,
    input logic [NUM_CH-1:0] tc_pulse
);

    localparam logic [ADDR_W-1:0] FIRST_IDX = ADDR_W'(BASE_IDX);
    localparam logic [ADDR_W-1:0] END_IDX   = ADDR_W'(BASE_IDX + 2 * NUM_CH);

    logic unmapped_rd;
    assign unmapped_rd = reg_rd && ((reg_addr < FIRST_IDX) || (reg_addr >= END_IDX));

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(reg_rd) |-> $stable(reg_rdata)); // R11

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $past(unmapped_rd) |-> (reg_rdata == '0)); // R10

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] HI_IDX = ADDR_W'(BASE_IDX + 2 * c + 1);

        AST_TC_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
            tc_pulse[c] |-> $past(xfer_stb[c])); // R5

        AST_LOAD_SUPPRESSES_TC: assert property (@(posedge clk) disable iff (!rst_n)
            $past(reg_wr && (reg_addr == HI_IDX)) |-> !tc_pulse[c]); // R6
    end

endmodule

bind dma_xfer_counter dma_xfer_counter_chk #(
    .NUM_CH   (NUM_CH),
    .REG_W    (REG_W),
    .ADDR_W   (ADDR_W),
    .BASE_IDX (BASE_IDX)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_rd    (reg_rd),
    .reg_rdata (reg_rdata),
    .xfer_stb  (xfer_stb),
    .tc_pulse  (tc_pulse)
);

// File: tb/dma_xfer_counter_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks push expected read bytes, a monitor pops
// and compares them when reg_rdata becomes valid.
module dma_xfer_counter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_rdata;
    logic [1:0] xfer_stb = '0;
    logic [1:0] tc_pulse;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Scoreboard of pending read expectations.
    logic [7:0] exp_q[$];
    string      req_q[$];
    logic       rd_seen = 1'b0;

    // Bench model of each channel, built from the requirements.
    logic [15:0] m_cnt [2];
    logic [15:0] m_rel [2];
    logic [7:0]  m_stg [2];
    logic [7:0]  m_sh  [2];
    bit          m_shv [2];

    always #2.5 clk = ~clk;

    dma_xfer_counter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rd    (reg_rd),
        .reg_rdata (reg_rdata),
        .xfer_stb  (xfer_stb),
        .tc_pulse  (tc_pulse)
    );

    task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Monitor: a read sampled at a posedge is valid at the next negedge.
    always @(posedge clk) rd_seen <= reg_rd;
    always @(negedge clk) begin
        if (rd_seen && rst_n) begin
            if (exp_q.size() == 0) begin
                check8(reg_rdata, 8'hxx, "unexpected read");
            end else begin
                check8(reg_rdata, exp_q.pop_front(), req_q.pop_front());
            end
        end
    end

    // One bus cycle: drive at a negedge, release at the next.
    task automatic drive(input bit w, input bit r, input logic [7:0] a,
                         input logic [7:0] d, input logic [1:0] s);
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d; xfer_stb = s;
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0; xfer_stb = '0;
    endtask

    // Index map: 0Bh/0Ch channel 0, 0Dh/0Eh channel 1.
    function automatic bit mapped(input logic [7:0] a);
        return (a >= 8'h0B) && (a <= 8'h0E);
    endfunction
    function automatic int chan_of(input logic [7:0] a);
        return (a >= 8'h0D) ? 1 : 0;
    endfunction
    function automatic bit is_hi(input logic [7:0] a);
        return (a == 8'h0C) || (a == 8'h0E);
    endfunction

    function automatic void model_wr(input logic [7:0] a, input logic [7:0] d);
        int c;
        if (!mapped(a)) return;
        c = chan_of(a);
        if (is_hi(a)) begin
            m_cnt[c] = {d, m_stg[c]};
            m_rel[c] = {d, m_stg[c]};
            m_shv[c] = 1'b0;
        end else begin
            m_stg[c] = d;
        end
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        model_wr(a, d);
        drive(1'b1, 1'b0, a, d, 2'b00);
    endtask

    task automatic rd(input logic [7:0] a, input string req);
        logic [7:0] e;
        int c;
        if (!mapped(a)) begin
            e = 8'h00;
        end else begin
            c = chan_of(a);
            if (is_hi(a)) begin
                e = m_shv[c] ? m_sh[c] : m_cnt[c][15:8];
                m_shv[c] = 1'b0;
            end else begin
                e = m_cnt[c][7:0];
                m_sh[c] = m_cnt[c][15:8];
                m_shv[c] = 1'b1;
            end
        end
        exp_q.push_back(e);
        req_q.push_back(req);
        drive(1'b0, 1'b1, a, 8'h00, 2'b00);
    endtask

    // Strobe channels in s, optionally with a write; check terminal pulses.
    task automatic stb_wr(input logic [1:0] s, input bit w, input logic [7:0] a,
                          input logic [7:0] d, input string req);
        logic [1:0] etc;
        int lc;
        etc = '0;
        lc = (w && mapped(a) && is_hi(a)) ? chan_of(a) : -1;
        for (int c = 0; c < 2; c++) begin
            if (s[c] && c != lc) begin
                if (m_cnt[c] == 16'h0000) begin
                    m_cnt[c] = m_rel[c];
                    etc[c] = 1'b1;
                end else begin
                    m_cnt[c] = m_cnt[c] - 16'h0001;
                end
            end
        end
        if (w) model_wr(a, d);
        drive(w, 1'b0, a, d, s);
        check8({6'b0, tc_pulse}, {6'b0, etc}, req);
    endtask

    task automatic stb(input logic [1:0] s, input string req);
        stb_wr(s, 1'b0, 8'h00, 8'h00, req);
    endtask

    task automatic rd16(input int c, input string req);
        rd(c == 0 ? 8'h0B : 8'h0D, req);
        rd(c == 0 ? 8'h0C : 8'h0E, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 2; c++) begin
            m_cnt[c] = 16'hFFFF; m_rel[c] = 16'hFFFF;
            m_stg[c] = 8'hFF;    m_sh[c]  = 8'hFF; m_shv[c] = 1'b0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check8(reg_rdata, 8'h00, "R1 rdata after reset");
        check8({6'b0, tc_pulse}, 8'h00, "R1 tc after reset");
        rd(8'h0B, "R1 play lo FF"); rd(8'h0C, "R1 play hi FF");
        rd(8'h0D, "R1 rec lo FF");  rd(8'h0E, "R1 rec hi FF");

        // R2: low write only stages
        wr(8'h0B, 8'h34);
        rd(8'h0B, "R2 staged lo not visible");
        rd(8'h0C, "R2 hi unchanged");

        // R3: atomic load on high write
        wr(8'h0C, 8'h12);
        rd16(0, "R3 loaded 1234");

        // R4: decrement per strobe
        stb(2'b01, "R4 strobe no tc");
        stb(2'b01, "R4 strobe no tc");
        stb(2'b01, "R4 strobe no tc");
        rd16(0, "R4 count 1231");

        // R5: load 0002h, pulse on third strobe, reload
        wr(8'h0B, 8'h02); wr(8'h0C, 8'h00);
        stb(2'b01, "R5 strobe 1");
        stb(2'b01, "R5 strobe 2");
        stb(2'b01, "R5 underflow pulse");
        rd16(0, "R5 reloaded 0002");
        stb(2'b01, "R5 pulse only one cycle");
        rd16(0, "R5 count 0001");

        // R6: load wins over simultaneous strobe at zero
        wr(8'h0B, 8'h00); wr(8'h0C, 8'h00);
        wr(8'h0B, 8'h07);
        stb_wr(2'b01, 1'b1, 8'h0C, 8'h00, "R6 load with strobe no tc");
        rd16(0, "R6 count 0007 no decrement");

        // R7: coherent read through shadow
        wr(8'h0D, 8'h00); wr(8'h0E, 8'h01);
        rd(8'h0D, "R7 rec lo 00");
        stb(2'b10, "R7 strobe to 00FF");
        rd(8'h0E, "R7 hi from shadow 01");

        // R8: shadow consumed, and dropped by high write
        rd(8'h0E, "R8 live hi 00");
        rd(8'h0D, "R8 lo FF arms shadow");
        wr(8'h0E, 8'h05);
        rd(8'h0E, "R8 hi after write live 05");

        // R9: channel isolation
        wr(8'h0D, 8'h00); wr(8'h0E, 8'h00);
        stb(2'b10, "R9 rec pulse only");
        stb(2'b10, "R9 rec pulse again");
        rd16(0, "R9 play untouched");
        stb(2'b11, "R9 both strobed");
        rd16(0, "R9 play decremented once");
        rd16(1, "R9 rec own count");

        // R10: unmapped indices
        rd(8'h0A, "R10 unmapped 0A reads 00");
        rd(8'h0F, "R10 unmapped 0F reads 00");
        wr(8'h0F, 8'hAA); wr(8'h0A, 8'h55); wr(8'h10, 8'h77);
        rd16(0, "R10 play unchanged");
        rd16(1, "R10 rec unchanged");

        // R11: rdata holds without a read, even as counters move
        rd(8'h0B, "R11 setup read");
        stb(2'b01, "R11 strobe");
        stb(2'b01, "R11 strobe");
        check8(reg_rdata, exp_lastlo(), "R11 rdata held");

        repeat (3) @(negedge clk);
        check8(8'(exp_q.size()), 8'h00, "scoreboard drained");
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Low byte of channel 0 as it stood before the two R11 strobes.
    function automatic logic [7:0] exp_lastlo();
        logic [15:0] v;
        v = m_cnt[0] + 16'h0002;
        return v[7:0];
    endfunction

endmodule